// File: doc/BRIEF.md
# Glitch-free clock stop gate

This block drives a group of clock outputs derived from one fast clock and removes the high phases of selected outputs when an active-low stop request arrives. A phase generator inside the block sets the output period to 2*HALF fast-clock cycles, split into a low half and a high half of equal length. The stop request is asynchronous, so it is first taken through a fast-clock synchronizer. It then passes a short chain of gate stages that advance only at the end of a high phase. The decision for each output is made at the start of each high phase and held for the whole of that phase. An output therefore stops in the low state and, when it restarts, its first high pulse is full width.

Two parameter sets cover the two intended uses. The processor-clock group has three outputs, two gate stages and a larger latency allowance, and only output 0 responds to the stop request. The bus-clock group has seven outputs and one gate stage, and output 0 always runs. A per-output enable mask keeps an output low whatever the stop request does.

Top module: `clk_stop_gate`

## Requirements
- R1: `stop_n` reaches the gate only through SYNC_DEPTH fast-clock flip-flops followed by GATE_STAGES stages. These stages update only at the end of a high phase, so the internal run enable never changes at any other time.
- R2: An output that is stopped or disabled rests at 0. A gated output is high only while the internal reference phase is high.
- R3: Every high pulse on every output lasts exactly HALF fast cycles, including the first pulse after a restart. Outputs change only at reference phase boundaries.
- R4: With GATE_STAGES=2 (processor group, FREE_MASK=3'b110), at most 2 further high pulses appear on `clk_out[0]` after `stop_n` falls. After `stop_n` rises, at most 2 reference high phases pass before `clk_out[0]` resumes.
- R5: With GATE_STAGES=1 (bus group, FREE_MASK=7'b0000001), at most 1 further high pulse appears on a gated output after `stop_n` falls. After `stop_n` rises, at most 1 reference high phase passes before the output resumes.
- R6: Outputs whose FREE_MASK bit is 1 ignore `stop_n` and toggle every period whenever they are enabled.
- R7: `en_mask[i]=0` holds `clk_out[i]` at 0 whatever `stop_n` is. The mask is sampled at the start of each high phase.
- R8: While `rst` is high, all outputs are 0 and the run enable is set to running. After release, the reference is low for HALF cycles and then high, and every enabled output rises together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from which the outputs are derived |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| en_mask | input | N_OUT | Per-output enable, 1 = may run |
| clk_out | output | N_OUT | Gated clock outputs, registered |

## Verification
The bench drops and raises the stop request at every fast-cycle offset within an output period. This catches a gate that counts too few or too many stages: such a gate lets extra high pulses through after a stop, or misses extra phases before a restart. A pulse-width monitor on every output catches a gate that acts mid-phase, because that design would produce a runt high pulse when stopping or starting. A table of stop and mask patterns on both parameter sets catches exempt outputs that are wrongly gated and masked outputs that leak through.

// File: rtl/cg_pkg.sv
package cg_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } ph_evt_t;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cg_phase_gen.sv
module cg_phase_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ph,
  output cg_pkg::ph_evt_t  evt
);
  localparam int unsigned CW = cg_pkg::cnt_w(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == LAST);
  assign evt.rise = wrap & ~ph;
  assign evt.fall = wrap & ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cg_req_sync.sv
module cg_req_sync #(
  parameter int unsigned SYNC_DEPTH  = 2,
  parameter int unsigned GATE_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_n,
  input  logic fall_ev,
  output logic run_en
);
  logic [SYNC_DEPTH-1:0]  sy;
  logic [GATE_STAGES-1:0] gs;

  generate
    if (SYNC_DEPTH == 1) begin : g_sy1
      always_ff @(posedge clk) begin
        if (rst) sy <= '1;
        else     sy <= stop_n;
      end
    end else begin : g_syn
      always_ff @(posedge clk) begin
        if (rst) sy <= '1;
        else     sy <= {sy[SYNC_DEPTH-2:0], stop_n};
      end
    end

    if (GATE_STAGES == 1) begin : g_gs1
      always_ff @(posedge clk) begin
        if (rst)          gs <= '1;
        else if (fall_ev) gs <= sy[SYNC_DEPTH-1];
      end
    end else begin : g_gsn
      always_ff @(posedge clk) begin
        if (rst)          gs <= '1;
        else if (fall_ev) gs <= {gs[GATE_STAGES-2:0], sy[SYNC_DEPTH-1]};
      end
    end
  endgenerate

  assign run_en = gs[GATE_STAGES-1];

  // R1
  run_upd_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(run_en) |-> $past(fall_ev))
    else $error("run enable changed outside a phase end");

endmodule

// File: rtl/cg_out_gate.sv
module cg_out_gate #(
  parameter int unsigned          N_OUT     = 3,
  parameter logic [N_OUT-1:0]     FREE_MASK = 3'b110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ph,
  input  cg_pkg::ph_evt_t  evt,
  input  logic             run_en,
  input  logic [N_OUT-1:0] mask,
  output logic [N_OUT-1:0] out_q
);

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_bit
      logic allow;
      if (FREE_MASK[i]) begin : g_free
        assign allow = mask[i];
      end else begin : g_gated
        assign allow = mask[i] & run_en;
      end

      always_ff @(posedge clk) begin
        if (rst)           out_q[i] <= 1'b0;
        else if (evt.fall) out_q[i] <= 1'b0;
        else if (evt.rise) out_q[i] <= allow;
      end

      // R2
      rest_low_chk: assert property (@(posedge clk) disable iff (rst)
        out_q[i] |-> ph)
        else $error("output high while reference low");

      // R3
      edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_q[i]) |-> $past(evt.rise || evt.fall))
        else $error("output moved away from a phase boundary");

      // R7
      mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q[i]) |-> $past(mask[i]))
        else $error("disabled output rose");

      if (FREE_MASK[i]) begin : g_free_chk
        // R6
        free_run_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(ph) |-> (out_q[i] == $past(mask[i])))
          else $error("exempt output was gated");
      end else begin : g_gate_chk
        // R2
        stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(out_q[i]) |-> $past(run_en))
          else $error("gated output rose while stopped");
      end
    end
  endgenerate

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned      N_OUT       = 3,
  parameter int unsigned      HALF        = 2,
  parameter int unsigned      SYNC_DEPTH  = 2,
  parameter int unsigned      GATE_STAGES = 2,
  parameter logic [N_OUT-1:0] FREE_MASK   = 3'b110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_n,
  input  logic [N_OUT-1:0] en_mask,
  output logic [N_OUT-1:0] clk_out
);
  cg_pkg::ph_evt_t evt;
  logic            ph;
  logic            run_en;

  cg_phase_gen #(.HALF(HALF)) u_phase (
    .clk (clk),
    .rst (rst),
    .ph  (ph),
    .evt (evt)
  );

  cg_req_sync #(.SYNC_DEPTH(SYNC_DEPTH), .GATE_STAGES(GATE_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .stop_n  (stop_n),
    .fall_ev (evt.fall),
    .run_en  (run_en)
  );

  cg_out_gate #(.N_OUT(N_OUT), .FREE_MASK(FREE_MASK)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .ph     (ph),
    .evt    (evt),
    .run_en (run_en),
    .mask   (en_mask),
    .out_q  (clk_out)
  );

endmodule

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
  localparam int HALF = 2;
  localparam int P    = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c_stop_n = 1'b1;
  logic p_stop_n = 1'b1;
  logic [2:0] c_mask = 3'b111;
  logic [6:0] p_mask = 7'b1111111;
  logic [2:0] c_out;
  logic [6:0] p_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_stop_gate #(.N_OUT(3), .HALF(HALF), .SYNC_DEPTH(2), .GATE_STAGES(2),
                  .FREE_MASK(3'b110)) i_clk_stop_gate (
    .clk(clk), .rst(rst), .stop_n(c_stop_n), .en_mask(c_mask), .clk_out(c_out));

  clk_stop_gate #(.N_OUT(7), .HALF(HALF), .SYNC_DEPTH(2), .GATE_STAGES(1),
                  .FREE_MASK(7'b0000001)) i_clk_stop_gate_pci (
    .clk(clk), .rst(rst), .stop_n(p_stop_n), .en_mask(p_mask), .clk_out(p_out));

  // monitor: sampled 2 ns after each rising edge
  int c_grise = 0, c_frise = 0, p_grise = 0, p_frise = 0;
  int bad_width = 0;
  int hc_c [3];
  int hc_p [7];
  logic [2:0] c_prev = '0;
  logic [6:0] p_prev = '0;

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (c_out[0] && !c_prev[0]) c_grise++;
      if (c_out[1] && !c_prev[1]) c_frise++;
      if (p_out[1] && !p_prev[1]) p_grise++;
      if (p_out[0] && !p_prev[0]) p_frise++;
      for (int i = 0; i < 3; i++) begin
        if (c_out[i]) hc_c[i]++;
        else begin
          if (c_prev[i] && hc_c[i] != HALF) bad_width++;
          hc_c[i] = 0;
        end
      end
      for (int i = 0; i < 7; i++) begin
        if (p_out[i]) hc_p[i]++;
        else begin
          if (p_prev[i] && hc_p[i] != HALF) bad_width++;
          hc_p[i] = 0;
        end
      end
    end
    c_prev = c_out;
    p_prev = p_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {c_stop_n, c_mask, c_exp, p_stop_n, p_mask, p_exp}
  localparam logic [21:0] VEC [8] = '{
    {1'b1, 3'b111, 3'b111, 1'b1, 7'b1111111, 7'b1111111},
    {1'b0, 3'b111, 3'b110, 1'b0, 7'b1111111, 7'b0000001},
    {1'b1, 3'b101, 3'b101, 1'b1, 7'b0000001, 7'b0000001},
    {1'b0, 3'b011, 3'b010, 1'b0, 7'b1111110, 7'b0000000},
    {1'b1, 3'b000, 3'b000, 1'b1, 7'b0101010, 7'b0101010},
    {1'b0, 3'b001, 3'b000, 1'b0, 7'b0000001, 7'b0000001},
    {1'b0, 3'b110, 3'b110, 1'b1, 7'b1111110, 7'b1111110},
    {1'b1, 3'b111, 3'b111, 1'b0, 7'b1010101, 7'b0000001}
  };

  task automatic wait_c_frise();
    int f0 = c_frise;
    while (c_frise == f0) @(negedge clk);
  endtask

  task automatic wait_p_frise();
    int f0 = p_frise;
    while (p_frise == f0) @(negedge clk);
  endtask

  task automatic cpu_latency(input int off);
    int g0, g1, f0, guard;
    wait_c_frise();
    repeat (off) @(negedge clk);
    g0 = c_grise;
    c_stop_n = 1'b0;
    @(negedge clk);
    // R1: the phase under way is not cut by the request
    chk(c_out[0] == c_out[1], "R1 cpu phase kept", c_out[0], c_out[1]);
    repeat (6 * P) @(negedge clk);
    g1 = c_grise;
    chk((g1 - g0) <= 2, "R4 cpu off latency", g1 - g0, 2);
    repeat (3 * P) @(negedge clk);
    chk(c_grise == g1 && c_out[0] == 1'b0, "R2 cpu rests low", c_grise - g1, 0);
    f0 = c_frise;
    c_stop_n = 1'b1;
    guard = 0;
    while (c_grise == g1 && guard < 8 * P) begin
      @(negedge clk);
      guard++;
    end
    chk(c_grise != g1 && (c_frise - f0 - 1) <= 2, "R4 cpu on latency",
        c_frise - f0 - 1, 2);
  endtask

  task automatic pci_latency(input int off);
    int g0, g1, f0, guard;
    wait_p_frise();
    repeat (off) @(negedge clk);
    g0 = p_grise;
    p_stop_n = 1'b0;
    repeat (6 * P) @(negedge clk);
    g1 = p_grise;
    chk((g1 - g0) <= 1, "R5 pci off latency", g1 - g0, 1);
    repeat (3 * P) @(negedge clk);
    chk(p_grise == g1 && p_out[6:1] == 6'b0, "R2 pci rests low", p_out, 0);
    f0 = p_frise;
    p_stop_n = 1'b1;
    guard = 0;
    while (p_grise == g1 && guard < 8 * P) begin
      @(negedge clk);
      guard++;
    end
    chk(p_grise != g1 && (p_frise - f0 - 1) <= 1, "R5 pci on latency",
        p_frise - f0 - 1, 1);
  endtask

  initial begin
    logic [2:0] c_tog, c_hi;
    logic [6:0] p_tog, p_hi;
    logic [2:0] c_last;
    logic [6:0] p_last;
    int guard;
    // R8: reset state
    repeat (5) @(negedge clk);
    chk(c_out == 3'b000 && p_out == 7'b0, "R8 reset outputs low", {c_out, p_out}, 0);
    rst = 1'b0;
    guard = 0;
    while (!c_out[1] && guard < 4 * P) begin
      @(negedge clk);
      guard++;
    end
    chk(c_out == 3'b111 && p_out == 7'b1111111, "R8 first rise after reset",
        {c_out, p_out}, 10'h3ff);

    // table walk: R6 R7
    for (int r = 0; r < 8; r++) begin
      logic [21:0] v;
      v = VEC[r];
      @(negedge clk);
      c_stop_n = v[21];
      c_mask   = v[20:18];
      p_stop_n = v[14];
      p_mask   = v[13:7];
      repeat (6 * P) @(negedge clk);
      c_tog = '0; c_hi = '0; p_tog = '0; p_hi = '0;
      c_last = c_out; p_last = p_out;
      repeat (3 * P) begin
        @(negedge clk);
        c_tog |= c_out ^ c_last;
        p_tog |= p_out ^ p_last;
        c_hi  |= c_out;
        p_hi  |= p_out;
        c_last = c_out;
        p_last = p_out;
      end
      chk(c_tog == v[17:15] && c_hi == v[17:15], "R6 R7 cpu pattern", c_tog, v[17:15]);
      chk(p_tog == v[6:0] && p_hi == v[6:0], "R6 R7 pci pattern", p_tog, v[6:0]);
    end

    @(negedge clk);
    c_stop_n = 1'b1; p_stop_n = 1'b1;
    c_mask = 3'b111; p_mask = 7'b1111111;
    repeat (6 * P) @(negedge clk);
    for (int off = 0; off < P; off++) cpu_latency(off);
    for (int off = 0; off < P; off++) pci_latency(off);

    repeat (2 * P) @(negedge clk);
    chk(bad_width == 0, "R3 full-width high pulses", bad_width, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule